// File: doc/BRIEF.md
# Multi-Locality Access Arbiter

This block decides which of five privilege windows, called localities, owns a security coprocessor at any moment. Each locality reaches its own one-byte access register through a separate address window, chosen by address bits [14:12]. A locality asks for ownership by writing a request bit. If the device is idle, the request is granted at once. Otherwise the request waits, and the current owner can see that another locality is waiting. The owner gives the device up by writing its active bit, and the highest-numbered waiting locality then takes over.

After reset the block stays unusable for a fixed, parameterised number of cycles. During that time the valid flag reads 0, and the block ignores every request and every relinquish. Downstream logic follows the current owner through a registered owner output and a one-cycle pulse that marks every change of owner.

Top module: `locality_arbiter`

## Requirements
- R1: The valid flag (bit 7) reads 0 in every window for the first INIT_CYCLES clock edges after reset is released. It reads 1 from then on until the next reset.
- R2: While valid is 0, every access read returns 0x00 and every write is ignored, so no locality becomes owner.
- R3: Locality l (0 to 4) has its access register at address (l << 12), with address bits [11:0] all zero. Any other address, including windows 5 to 7, reads 0x00 and ignores writes. In every access register, bits 6, 4, 3, 1 and 0 always read 0.
- R4: Bit 5 (active) reads 1 only in the window of the owning locality. active_vld_o is 1 when some locality owns the device, and active_loc_o then holds its number. With no owner, active_loc_o is 0.
- R5: Suppose a locality writes a byte with bit 1 (request-use, 0x02) set while no locality owns the device. From the next cycle on, that locality is the owner.
- R6: Suppose a non-owner writes bit 1 while another locality owns the device. That request becomes pending. Bit 2 (request-pending, 0x04) then reads 1 in the owner's window while any request is pending. It always reads 0 in every other window.
- R7: A write with bit 5 (0x20) set in the owner's window relinquishes ownership. The highest-numbered pending locality becomes owner next cycle, and its pending request is cleared. If nothing is pending, there is no owner. When the owner's write has both bit 5 and bit 1 set, only the relinquish takes effect.
- R8: A request-use write from the current owner has no effect. A bit-5 write from a non-owner does not change ownership, and any pending request of that locality is kept.
- R9: loc_chg_o is high for exactly one cycle, the first cycle in which a new owner or the loss of the owner is visible on active_vld_o/active_loc_o. It is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 15 | Register byte address |
| wr_en_i | input | 1 | Write strobe for wdata_i at addr_i |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| active_vld_o | output | 1 | Some locality owns the device |
| active_loc_o | output | 3 | Number of the owning locality |
| loc_chg_o | output | 1 | One-cycle pulse when ownership changes |

## Verification
The main arbitration is tried with a request on an idle device, queued requests from a lower and a higher locality than the owner, and a relinquish with two waiters. These cases separate direct grant, queuing and the highest-number-first order. Owner re-requests, relinquish writes from non-owners, writes to window 5 and to a non-zero offset, and a write that sets request and relinquish together show which writes must leave ownership unchanged. A write issued during the initialization window, together with a cycle-exact check of when valid rises, separates the timer's edge count from a design that accepts requests too early. Each owner change is followed by a check one cycle later that the change pulse is exactly one cycle wide.

// File: rtl/loc_arb_pkg.sv
package loc_arb_pkg;
  localparam int unsigned ACC_VALID_BIT  = 7;
  localparam int unsigned ACC_ACTIVE_BIT = 5;
  localparam int unsigned ACC_PEND_BIT   = 2;
  localparam int unsigned ACC_REQ_BIT    = 1;

  typedef struct packed {
    logic rel;
    logic req;
  } acc_cmd_t;
endpackage

// File: rtl/loc_init_timer.sv
module loc_init_timer #(
  parameter int unsigned INIT_CYCLES = 8,
  localparam int unsigned CNT_W = $clog2(INIT_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic valid_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else if (!valid_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CNT_W'(INIT_CYCLES - 1)) valid_q <= 1'b1;
    end
  end

  assign valid_o = valid_q;
endmodule

// File: rtl/loc_addr_decode.sv
module loc_addr_decode #(
  parameter int unsigned ADDR_W    = 15,
  parameter int unsigned WIN_SHIFT = 12,
  parameter int unsigned NUM_LOC   = 5,
  parameter int unsigned LOC_W     = 3,
  localparam int unsigned SEL_W    = ADDR_W - WIN_SHIFT
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [LOC_W-1:0]  loc_o
);
  logic [SEL_W-1:0] sel;

  assign sel   = addr_i[ADDR_W-1:WIN_SHIFT];
  assign hit_o = (addr_i[WIN_SHIFT-1:0] == '0) &&
                 ({1'b0, sel} < (SEL_W + 1)'(NUM_LOC));
  assign loc_o = LOC_W'(sel);
endmodule

// File: rtl/loc_pick_highest.sv
module loc_pick_highest #(
  parameter int unsigned NUM_LOC = 5,
  parameter int unsigned LOC_W   = 3
) (
  input  logic [NUM_LOC-1:0] req_i,
  output logic               any_o,
  output logic [LOC_W-1:0]   idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < int'(NUM_LOC); i++) begin
      if (req_i[i]) idx_o = LOC_W'(i);
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/locality_arbiter.sv
module locality_arbiter
  import loc_arb_pkg::*;
#(
  parameter int unsigned NUM_LOC     = 5,
  parameter int unsigned ADDR_W      = 15,
  parameter int unsigned WIN_SHIFT   = 12,
  parameter int unsigned INIT_CYCLES = 8,
  localparam int unsigned LOC_W      = $clog2(NUM_LOC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              active_vld_o,
  output logic [LOC_W-1:0]  active_loc_o,
  output logic              loc_chg_o
);
  logic               valid_q;
  logic               win_hit;
  logic [LOC_W-1:0]   win_loc;
  logic [LOC_W-1:0]   owner_q, owner_d;
  logic               own_vld_q, own_vld_d;
  logic [NUM_LOC-1:0] pend_q, pend_d;
  logic               chg_q;
  logic               pick_any;
  logic [LOC_W-1:0]   pick_idx;
  logic               wr_ok, is_owner;
  acc_cmd_t           cmd;
  logic [7:0]         acc_byte [NUM_LOC];

  loc_init_timer #(.INIT_CYCLES(INIT_CYCLES)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_o(valid_q)
  );

  loc_addr_decode #(
    .ADDR_W(ADDR_W), .WIN_SHIFT(WIN_SHIFT), .NUM_LOC(NUM_LOC), .LOC_W(LOC_W)
  ) u_dec (
    .addr_i(addr_i),
    .hit_o (win_hit),
    .loc_o (win_loc)
  );

  loc_pick_highest #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) u_pick (
    .req_i(pend_q),
    .any_o(pick_any),
    .idx_o(pick_idx)
  );

  assign wr_ok    = wr_en_i && win_hit && valid_q;
  assign is_owner = own_vld_q && (win_loc == owner_q);
  // owner: relinquish wins over request; non-owner: only request counts
  assign cmd.rel  = wr_ok && is_owner && wdata_i[ACC_ACTIVE_BIT];
  assign cmd.req  = wr_ok && !is_owner && wdata_i[ACC_REQ_BIT];

  always_comb begin
    owner_d   = owner_q;
    own_vld_d = own_vld_q;
    pend_d    = pend_q;
    if (cmd.rel) begin
      if (pick_any) begin
        owner_d          = pick_idx;
        own_vld_d        = 1'b1;
        pend_d[pick_idx] = 1'b0;
      end else begin
        owner_d   = '0;
        own_vld_d = 1'b0;
      end
    end else if (cmd.req) begin
      if (!own_vld_q) begin
        owner_d   = win_loc;
        own_vld_d = 1'b1;
      end else begin
        pend_d[win_loc] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owner_q   <= '0;
      own_vld_q <= 1'b0;
      pend_q    <= '0;
      chg_q     <= 1'b0;
    end else begin
      owner_q   <= owner_d;
      own_vld_q <= own_vld_d;
      pend_q    <= pend_d;
      chg_q     <= (owner_d != owner_q) || (own_vld_d != own_vld_q);
    end
  end

  for (genvar l = 0; l < NUM_LOC; l++) begin : g_acc
    logic own_l;
    assign own_l = own_vld_q && (owner_q == LOC_W'(l));
    always_comb begin
      acc_byte[l]                 = 8'h00;
      acc_byte[l][ACC_VALID_BIT]  = 1'b1;
      acc_byte[l][ACC_ACTIVE_BIT] = own_l;
      acc_byte[l][ACC_PEND_BIT]   = own_l && (|pend_q);
    end
  end

  assign rdata_o      = (valid_q && win_hit) ? acc_byte[win_loc] : 8'h00;
  assign active_vld_o = own_vld_q;
  assign active_loc_o = owner_q;
  assign loc_chg_o    = chg_q;
endmodule

// File: rtl/loc_arb_chk.sv
module loc_arb_chk #(
  parameter int unsigned NUM_LOC = 5,
  parameter int unsigned LOC_W   = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [7:0]       wdata_i,
  input logic [7:0]       rdata_o,
  input logic             active_vld_o,
  input logic [LOC_W-1:0] active_loc_o,
  input logic             loc_chg_o,
  input logic             valid_i,
  input logic             hit_i,
  input logic [LOC_W-1:0] loc_i
);
  p_valid_sticky_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_i);

  p_no_owner_early_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> !active_vld_o);

  p_active_needs_valid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[5] |-> rdata_o[7]);

  p_idle_loc_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_vld_o |-> (active_loc_o == '0));

  p_direct_grant_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && hit_i && wr_en_i && wdata_i[1] && !active_vld_o)
    |=> (active_vld_o && active_loc_o == $past(loc_i)));

  p_pend_only_owner_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[2] |-> rdata_o[5]);

  p_owner_req_noop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && hit_i && wr_en_i && active_vld_o && loc_i == active_loc_o && !wdata_i[5])
    |=> ($stable(active_vld_o) && $stable(active_loc_o)));

  p_nonowner_keeps_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && active_vld_o && loc_i != active_loc_o)
    |=> (active_vld_o && $stable(active_loc_o)));

  p_chg_on_change_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_vld_o != $past(active_vld_o) || active_loc_o != $past(active_loc_o))
    |-> loc_chg_o);

  p_chg_only_change_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loc_chg_o
    |-> (active_vld_o != $past(active_vld_o) || active_loc_o != $past(active_loc_o)));
endmodule

bind locality_arbiter loc_arb_chk #(.NUM_LOC(NUM_LOC), .LOC_W(LOC_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .wdata_i     (wdata_i),
  .rdata_o     (rdata_o),
  .active_vld_o(active_vld_o),
  .active_loc_o(active_loc_o),
  .loc_chg_o   (loc_chg_o),
  .valid_i     (valid_q),
  .hit_i       (win_hit),
  .loc_i       (win_loc)
);

// File: tb/locality_arbiter_tb_top.sv
module locality_arbiter_tb_top;
  localparam int unsigned INIT_CYCLES = 8;
  localparam int NVEC = 13;
  // {wloc[3], wdata[8], rloc[3], exp_rdata[8], exp_vld, exp_loc[3], exp_chg}
  localparam logic [26:0] VEC [NVEC] = '{
    {3'd2, 8'h02, 3'd2, 8'hA0, 1'b1, 3'd2, 1'b1},
    {3'd0, 8'h02, 3'd2, 8'hA4, 1'b1, 3'd2, 1'b0},
    {3'd4, 8'h02, 3'd0, 8'h80, 1'b1, 3'd2, 1'b0},
    {3'd2, 8'h02, 3'd2, 8'hA4, 1'b1, 3'd2, 1'b0},
    {3'd0, 8'h20, 3'd2, 8'hA4, 1'b1, 3'd2, 1'b0},
    {3'd2, 8'h20, 3'd4, 8'hA4, 1'b1, 3'd4, 1'b1},
    {3'd4, 8'h20, 3'd0, 8'hA0, 1'b1, 3'd0, 1'b1},
    {3'd0, 8'h22, 3'd0, 8'h80, 1'b0, 3'd0, 1'b1},
    {3'd5, 8'h02, 3'd3, 8'h80, 1'b0, 3'd0, 1'b0},
    {3'd3, 8'h22, 3'd3, 8'hA0, 1'b1, 3'd3, 1'b1},
    {3'd1, 8'h02, 3'd3, 8'hA4, 1'b1, 3'd3, 1'b0},
    {3'd3, 8'h20, 3'd1, 8'hA0, 1'b1, 3'd1, 1'b1},
    {3'd1, 8'h20, 3'd1, 8'h80, 1'b0, 3'd0, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [14:0] addr = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        act_vld;
  logic [2:0]  act_loc;
  logic        chg;
  int n_total = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  locality_arbiter #(.INIT_CYCLES(INIT_CYCLES)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .addr_i      (addr),
    .wr_en_i     (wr_en),
    .wdata_i     (wdata),
    .rdata_o     (rdata),
    .active_vld_o(act_vld),
    .active_loc_o(act_loc),
    .loc_chg_o   (chg)
  );

  function automatic string vtag(int i);
    case (i)
      0, 9:           return "R5";
      1, 2, 10:       return "R6";
      3, 4:           return "R8";
      8:              return "R3";
      default:        return "R7";
    endcase
  endfunction

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    n_total++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  // write presented at a negedge, taken at the next posedge; returns at the following negedge
  task automatic wr(logic [14:0] a, logic [7:0] d);
    addr  = a;
    wdata = d;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_check(string req, logic [14:0] a, logic [7:0] exp);
    addr = a;
    #1;
    check(req, rdata, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_total++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rd_check("R2", 15'h0000, 8'h00);
    check("R4", {7'd0, act_vld}, 8'h00);
    rst_n = 1'b1;                       // released at a negedge
    @(negedge clk);                     // negedge 1
    wr(15'h0000, 8'h02);                // early request, must be ignored (R2)
    repeat (5) @(negedge clk);          // negedge 7
    rd_check("R1", 15'h0000, 8'h00);
    @(negedge clk);                     // negedge 8
    rd_check("R1", 15'h0000, 8'h80);
    check("R2", {7'd0, act_vld}, 8'h00);
    rd_check("R3", 15'h1018, 8'h00);    // non-zero offset reads 0
    rd_check("R3", 15'h5000, 8'h00);    // window 5 reads 0

    for (int i = 0; i < NVEC; i++) begin
      logic [26:0] v;
      v = VEC[i];
      @(negedge clk);
      wr({v[26:24], 12'h000}, v[23:16]);
      check({vtag(i), " R9 chg"}, {7'd0, chg}, {7'd0, v[0]});
      rd_check({vtag(i), " rdata"}, {v[15:13], 12'h000}, v[12:5]);
      check({vtag(i), " R4 owner"}, {4'd0, act_vld, act_loc}, {4'd0, v[4], v[3:1]});
    end

    // write at a non-zero offset is ignored
    @(negedge clk);
    wr(15'h1018, 8'h02);
    check("R3 offset write", {4'd0, act_vld, act_loc}, 8'h00);

    // pulse lasts one cycle only
    wr(15'h2000, 8'h02);
    check("R9 pulse high", {7'd0, chg}, 8'h01);
    @(negedge clk);
    check("R9 pulse low", {7'd0, chg}, 8'h00);
    rd_check("R4 other window", 15'h1000, 8'h80);

    // owner relinquish with request bit also set leaves no owner, nothing queued
    wr(15'h2000, 8'h22);
    check("R7 rel+req", {4'd0, act_vld, act_loc}, 8'h00);

    // reset mid-run
    wr(15'h4000, 8'h02);
    rst_n = 1'b0;
    #1;
    rd_check("R2 reset", 15'h4000, 8'h00);
    check("R4 reset", {4'd0, act_vld, act_loc}, 8'h00);

    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule